// File: doc/BRIEF.md
# Serial/Parallel Nibble Entry Register for a Fall-Through Buffer

This block is the entry stage of a word-wide fall-through buffer. It builds one word either in a single step from a parallel bus or one bit at a time from a serial line. Each serial bit is taken on a falling edge of a slow serial clock, and those edges are found by sampling that clock on the system clock. A marker bit is placed in the top data stage at initialization and moves toward a fifth completion stage as bits arrive. When the marker reaches that stage, the word is complete and the active-low full flag drops. No bit counter is used.

A complete word is handed to the downstream stack with a one-cycle write strobe. The strobe fires when the transfer request is low and the stack reports that its top location is empty. A set/reset guard records the handoff, so the same word is never written twice while the request stays low. The register is then re-initialized, but only once the parallel load strobe is low. The full flag can be wired straight back to the transfer request, and the register then empties itself into the stack with no other logic.

Top module: `fifo_in_stage`

## Requirements
- R1: After `rst_n` low, or after one system clock with `mst_clr` high, `full_n` is 1 and `word_o` equals the initialized pattern. In that pattern only the most significant bit is 1, which is 4'b1000 for the default width.
- R2: With `ser_en_n` low, each falling edge of `ser_clk` shifts `ser_din` into the register within SYNC_STAGES+1 system clocks. The first bit received ends in bit 0 and the last in bit DATA_W-1. `full_n` stays 1 until the DATA_W-th edge and goes 0 after it.
- R3: While `par_load` is 1, each clock loads `par_din` into `word_o` and drives `full_n` to 0. A parallel load takes priority over a serial shift falling due in the same cycle.
- R4: Falling edges of `ser_clk` while `ser_en_n` is 1 leave `word_o` and `full_n` unchanged.
- R5: Once `full_n` is 0, further serial clock edges leave `word_o` and `full_n` unchanged.
- R6: `push` is 1 in a cycle only when `xfer_n` is 0, `top_empty` is 1, `full_n` is 0 and no handoff of the current word has yet happened. The word written is `word_o` in that cycle.
- R7: A push made while `par_load` is 0 re-initializes the register at the next clock, so `full_n` becomes 1 and `word_o` returns to the initialized pattern.
- R8: A push made while `par_load` is 1 leaves the register loaded and full. No second push follows while `par_load` stays 1. The register re-initializes at the first clock after `par_load` returns to 0.
- R9: `push` is never 1 in two consecutive cycles. While `top_empty` is 0, a full register keeps its word and does not push.
- R10: With `xfer_n` driven from `full_n` and `top_empty` at 1, every completed word, whether serial or parallel, is pushed exactly once and the register returns to the initialized state.
- R11: A rising edge of `ser_clk` alone does not change `word_o` or `full_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mst_clr | input | 1 | Synchronous clear of the register and the transfer guard |
| par_load | input | 1 | Parallel load strobe, active high, sampled as a level |
| ser_clk | input | 1 | Serial bit clock; its falling edges shift data |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_din | input | 1 | Serial data bit |
| par_din | input | DATA_W | Parallel data word |
| xfer_n | input | 1 | Transfer-to-stack request, active low |
| top_empty | input | 1 | Stack top location is free |
| full_n | output | 1 | Register full flag, active low |
| push | output | 1 | One-cycle write strobe to the stack |
| word_o | output | DATA_W | Register contents, written to the stack on `push` |

## Verification
The bench builds the block with DATA_W = 4 and SYNC_STAGES = 2. With these values a word fills after four serial edges, and each edge shifts three system clocks after it arrives. That brings several cases within reach of short directed runs: completion of the marker, the freeze after the fourth edge, a serial edge colliding with a parallel load, and a deferred re-initialization while the load strobe stays high. Seeded random words, loaded serially or in parallel with random stack-busy stretches, are checked against the word the bench itself sent.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INIT  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_SHIFT = 2'd3
  } reg_op_e;

endpackage

// File: rtl/fsi_fall_detect.sv
module fsi_fall_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    sync_d[0] = async_in;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
    prev_d = sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // High for one cycle after the sampled level goes from 1 to 0
  assign fall_o = prev_q & ~sync_q[LAST];

endmodule

// File: rtl/fsi_marker_reg.sv
module fsi_marker_reg
  import fsi_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_op_e           op,
  input  logic [DATA_W-1:0] par_din,
  input  logic              ser_din,
  output logic [DATA_W-1:0] word_o,
  output logic              done_o
);

  localparam logic [DATA_W-1:0] INIT_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] stage_q, stage_d;
  logic              done_q, done_d;

  always_comb begin
    stage_d = stage_q;
    done_d  = done_q;
    unique case (op)
      OP_INIT: begin
        stage_d = INIT_WORD;
        done_d  = 1'b0;
      end
      OP_LOAD: begin
        stage_d = par_din;
        done_d  = 1'b1;
      end
      OP_SHIFT: begin
        // New bit enters the top stage, the bottom stage feeds completion
        stage_d = {ser_din, stage_q[DATA_W-1:1]};
        done_d  = stage_q[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= INIT_WORD;
      done_q  <= 1'b0;
    end else if (op != OP_HOLD) begin
      stage_q <= stage_d;
      done_q  <= done_d;
    end
  end

  assign word_o = stage_q;
  assign done_o = done_q;

endmodule

// File: rtl/fsi_xfer_guard.sv
module fsi_xfer_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pl,
  input  logic xfer_n,
  input  logic top_empty,
  input  logic full,
  output logic push_o,
  output logic reinit_o,
  output logic guard_o
);

  logic guard_q, guard_d;
  logic push_w, reinit_w;

  always_comb begin
    push_w   = ~clr & ~xfer_n & top_empty & full & ~guard_q;
    // A completed handoff empties the register once the load strobe is gone
    reinit_w = (push_w | guard_q) & ~pl;
    guard_d  = guard_q;
    if (clr || reinit_w) begin
      guard_d = 1'b0;
    end else if (push_w) begin
      guard_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= 1'b0;
    end else begin
      guard_q <= guard_d;
    end
  end

  assign push_o   = push_w;
  assign reinit_o = reinit_w;
  assign guard_o  = guard_q;

endmodule

// File: rtl/fifo_in_stage.sv
module fifo_in_stage
  import fsi_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mst_clr,
  input  logic              par_load,
  input  logic              ser_clk,
  input  logic              ser_en_n,
  input  logic              ser_din,
  input  logic [DATA_W-1:0] par_din,
  input  logic              xfer_n,
  input  logic              top_empty,
  output logic              full_n,
  output logic              push,
  output logic [DATA_W-1:0] word_o
);

  logic    ser_fall;
  logic    done;
  logic    reinit;
  logic    guard_q;
  reg_op_e op;

  fsi_fall_detect #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ser_clk),
    .fall_o  (ser_fall)
  );

  fsi_xfer_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mst_clr),
    .pl       (par_load),
    .xfer_n   (xfer_n),
    .top_empty(top_empty),
    .full     (done),
    .push_o   (push),
    .reinit_o (reinit),
    .guard_o  (guard_q)
  );

  // Priority: clear / re-init, then parallel load, then serial shift
  always_comb begin
    if (mst_clr || reinit) begin
      op = OP_INIT;
    end else if (par_load) begin
      op = OP_LOAD;
    end else if (ser_fall && !ser_en_n && !done) begin
      op = OP_SHIFT;
    end else begin
      op = OP_HOLD;
    end
  end

  fsi_marker_reg #(
    .DATA_W(DATA_W)
  ) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .par_din(par_din),
    .ser_din(ser_din),
    .word_o (word_o),
    .done_o (done)
  );

  assign full_n = ~done;

endmodule

// File: rtl/fifo_in_stage_chk.sv
module fifo_in_stage_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mst_clr,
  input logic              par_load,
  input logic [DATA_W-1:0] par_din,
  input logic              full_n,
  input logic              push,
  input logic [DATA_W-1:0] word_o,
  input logic              guard_q
);

  localparam logic [DATA_W-1:0] INIT_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  a_r1_clear_init: assert property (@(posedge clk) disable iff (!rst_n)
    mst_clr |=> (full_n && word_o == INIT_WORD));

  a_r3_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (par_load && !mst_clr) |=> (!full_n && word_o == $past(par_din)));

  a_r5_full_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !par_load && !push && !guard_q && !mst_clr) |=> (!full_n && $stable(word_o)));

  a_r7_push_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !par_load) |=> full_n);

  a_r8_push_under_load: assert property (@(posedge clk) disable iff (!rst_n)
    (push && par_load && !mst_clr) |=> (!full_n && !push));

  a_r9_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

endmodule

bind fifo_in_stage fifo_in_stage_chk #(
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mst_clr (mst_clr),
  .par_load(par_load),
  .par_din (par_din),
  .full_n  (full_n),
  .push    (push),
  .word_o  (word_o),
  .guard_q (guard_q)
);

// File: tb/fifo_in_stage_test.sv
module fifo_in_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam logic [DW-1:0] INIT_W = 4'b1000;

  logic          clk;
  logic          rst_n;
  logic          mst_clr;
  logic          par_load;
  logic          ser_clk;
  logic          ser_en_n;
  logic          ser_din;
  logic [DW-1:0] par_din;
  logic          xfer_drv;
  logic          auto_mode;
  logic          xfer_n;
  logic          top_empty;
  logic          full_n;
  logic          push;
  logic [DW-1:0] word_o;

  int            n_chk;
  int            n_fail;
  int            push_cnt;
  logic [DW-1:0] last_word;
  bit            done;

  assign xfer_n = auto_mode ? full_n : xfer_drv;

  fifo_in_stage #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mst_clr(mst_clr), .par_load(par_load),
    .ser_clk(ser_clk), .ser_en_n(ser_en_n), .ser_din(ser_din),
    .par_din(par_din), .xfer_n(xfer_n), .top_empty(top_empty),
    .full_n(full_n), .push(push), .word_o(word_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (push) begin
      push_cnt++;
      last_word = word_o;
    end
  end

  // Word expected after sending bits v[0] first up to v[DW-1]
  function automatic logic [DW-1:0] serial_result(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = INIT_W;
    for (int i = 0; i < DW; i++) r = {v[i], r[DW-1:1]};
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b);
    ser_din = b;
    ser_clk = 1'b1;
    tick(4);
    ser_clk = 1'b0;
    tick(4);
  endtask

  task automatic ser_word(input logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) ser_bit(v[i]);
  endtask

  task automatic flush(input logic [DW-1:0] exp_w, input string req);
    int base;
    base = push_cnt;
    top_empty = 1'b1;
    xfer_drv = 1'b0;
    tick(3);
    xfer_drv = 1'b1;
    chk({req, " push count"}, push_cnt, base + 1);
    chk({req, " pushed word"}, last_word, exp_w);
    chk("R7 reinit full_n", full_n, 1);
    chk("R7 reinit word", word_o, INIT_W);
  endtask

  initial begin
    int base;
    logic [DW-1:0] v;
    n_chk = 0; n_fail = 0; push_cnt = 0; last_word = '0; done = 0;
    rst_n = 1'b0; mst_clr = 1'b0; par_load = 1'b0; ser_clk = 1'b0;
    ser_en_n = 1'b0; ser_din = 1'b0; par_din = '0; xfer_drv = 1'b1;
    auto_mode = 1'b0; top_empty = 1'b0;
    void'($urandom(32'd2718));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 reset full_n", full_n, 1);
    chk("R1 reset word", word_o, INIT_W);

    // R11 rising edge alone, then R2 serial entry of 4'b1011
    ser_din = 1'b1; ser_clk = 1'b1;
    tick(4);
    chk("R11 rising edge word", word_o, INIT_W);
    chk("R11 rising edge full_n", full_n, 1);
    ser_clk = 1'b0;
    tick(4);
    ser_bit(1'b1);
    chk("R2 partial full_n", full_n, 1);
    ser_bit(1'b0);
    chk("R2 three bits full_n", full_n, 1);
    ser_bit(1'b1);
    chk("R2 serial word", word_o, 4'b1011);
    chk("R2 full after fourth", full_n, 0);

    // R5 extra edges when full
    ser_bit(1'b0);
    ser_bit(1'b0);
    chk("R5 frozen word", word_o, 4'b1011);
    chk("R5 frozen full_n", full_n, 0);

    // R9 stack busy: no push, word kept
    base = push_cnt;
    xfer_drv = 1'b0; top_empty = 1'b0;
    tick(5);
    chk("R9 no push while busy", push_cnt, base);
    chk("R9 word kept while busy", word_o, 4'b1011);
    xfer_drv = 1'b1;
    flush(4'b1011, "R6");

    // R4 serial enable high
    ser_en_n = 1'b1;
    ser_word(4'b1111);
    chk("R4 disabled word", word_o, INIT_W);
    chk("R4 disabled full_n", full_n, 1);
    ser_en_n = 1'b0;

    // R1 master clear mid-word
    ser_bit(1'b1);
    ser_bit(1'b1);
    chk("R2 two bits in", word_o, 4'b1110);
    mst_clr = 1'b1;
    tick(1);
    mst_clr = 1'b0;
    chk("R1 clear word", word_o, INIT_W);
    chk("R1 clear full_n", full_n, 1);

    // R3 parallel load
    par_din = 4'h5; par_load = 1'b1;
    tick(2);
    chk("R3 load word", word_o, 4'h5);
    chk("R3 load full_n", full_n, 0);
    par_load = 1'b0;
    tick(2);
    chk("R3 word after strobe", word_o, 4'h5);
    flush(4'h5, "R6");

    // R3 priority: serial shift due in the same cycle as a load
    ser_clk = 1'b1; ser_din = 1'b1;
    tick(4);
    ser_clk = 1'b0;
    tick(1);
    par_din = 4'h6; par_load = 1'b1;
    tick(3);
    par_load = 1'b0;
    tick(2);
    chk("R3 load beats shift", word_o, 4'h6);

    // R8 push while load held high
    par_din = 4'h9; par_load = 1'b1;
    tick(1);
    base = push_cnt;
    xfer_drv = 1'b0; top_empty = 1'b1;
    tick(6);
    chk("R8 single push under load", push_cnt, base + 1);
    chk("R8 pushed word", last_word, 4'h9);
    chk("R8 still full under load", full_n, 0);
    par_load = 1'b0;
    tick(1);
    chk("R8 reinit after load drop", full_n, 1);
    chk("R8 word after load drop", word_o, INIT_W);
    tick(3);
    chk("R8 no extra push", push_cnt, base + 1);
    xfer_drv = 1'b1;

    // R10 automatic transfer
    auto_mode = 1'b1; top_empty = 1'b1;
    base = push_cnt;
    ser_word(4'b0110);
    chk("R10 auto serial push", push_cnt, base + 1);
    chk("R10 auto serial word", last_word, serial_result(4'b0110));
    chk("R10 auto serial empty", full_n, 1);
    par_din = 4'h3; par_load = 1'b1;
    tick(2);
    par_load = 1'b0;
    tick(3);
    chk("R10 auto parallel push", push_cnt, base + 2);
    chk("R10 auto parallel word", last_word, 4'h3);
    chk("R10 auto parallel empty", full_n, 1);
    auto_mode = 1'b0; top_empty = 1'b0;

    // Random words, serial or parallel, random stack-busy time
    for (int it = 0; it < 30; it++) begin
      int wait_n;
      v = DW'($urandom);
      wait_n = int'($urandom % 6);
      if ($urandom % 2 == 0) begin
        ser_word(v);
        chk("R2 random serial word", word_o, serial_result(v));
      end else begin
        par_din = v; par_load = 1'b1;
        tick(1);
        par_load = 1'b0;
        tick(1);
        chk("R3 random parallel word", word_o, v);
      end
      chk("R2 random full_n", full_n, 0);
      base = push_cnt;
      xfer_drv = 1'b0; top_empty = 1'b0;
      tick(wait_n + 1);
      chk("R9 random busy no push", push_cnt, base);
      xfer_drv = 1'b1;
      flush(v, "R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-R11 run actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule